// File: doc/BRIEF.md
# Phase-Shifted Multicarrier PWM Generator

This block produces the switch commands for one phase of a cascaded H-bridge inverter with a programmable number of output levels. For `NUM_LEVELS` levels it runs `NUM_LEVELS-1` triangular carriers. All carriers share the same amplitude and period. Their phases are spread evenly over one switching period, because an even spread gives the least output distortion. Each carrier is compared against a signed reference sample, and each comparison drives one complementary switch pair directly. The block also reports the synthesized output level, which is the signed sum of all the comparisons.

The carriers are up/down counters that swing between `-peak` and `+peak` in steps of one per clock. A full carrier cycle (the switching period) is therefore `4*peak` clocks, and `peak` sets the switching frequency: at 200 MHz, `peak = 50000` gives 1 kHz. The reference uses the same two's-complement scale as the carriers, so a modulation index of m corresponds to a sine amplitude of `m*peak`. Each comparator captures its own copy of the reference only when its carrier sits at a turning point, so a change in the reference never cuts a pulse short. Dropping the enable parks every carrier at its phase start and turns every switch off.

Top module: `phase_shift_pwm`

## Requirements
- R1: Carrier count and swing: there are NUM_LEVELS-1 carriers. While enabled, each carrier moves by exactly one count per clock between -peak and +peak, so its period is 4*peak clocks (peak ≥ 1, and 4*peak is a multiple of the carrier count).
- R2: Phase spread: carrier k starts at position k*4*peak/(NUM_LEVELS-1) of the triangle. Position 0 is -peak, rising. Position 2*peak is +peak, falling. In the 3-level case the two carriers are half a period apart.
- R3: While enabled, `gate_hi_o[k]` is 1 exactly when carrier k's captured reference is ≥ carrier k, and `gate_lo_o[k]` is its complement.
- R4: Each comparator captures `ref_i` only on a clock at which its carrier equals +peak or -peak, and also on every clock while disabled. A reference change in mid-ramp has no effect on the gates until the carrier's next turning point.
- R5: `level_o` equals 2*(number of gate_hi_o bits set) - (NUM_LEVELS-1) while enabled and 0 while disabled. It therefore takes only the NUM_LEVELS values -(NUM_LEVELS-1), -(NUM_LEVELS-3), …, +(NUM_LEVELS-1). A 0.8-index sine reaches both extreme levels in the 3-level case.
- R6: While `en_i` is low, all gate outputs are 0 and `level_o` is 0, from the same cycle onward. Every carrier is reloaded to its phase start on each clock.
- R7: `peak_i` is captured only while `en_i` is low. Changes to it while the block is enabled do not alter the carriers.
- R8: Boundary references: a reference of +peak keeps `gate_hi_o` high for the whole period. A reference of -peak sets it for one clock per period. A reference of -peak-1 never sets it.
- R9: With a constant reference r, -peak ≤ r < peak, each gate_hi_o bit is high for 2*(r+peak)+1 clocks of every 4*peak-clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low parks the carriers and turns the switches off |
| peak_i | input | DW-1 | Carrier peak magnitude (period = 4*peak clocks), unsigned |
| ref_i | input | DW | Signed reference sample on the carrier scale |
| gate_hi_o | output | NUM_LEVELS-1 | Upper switch command per carrier |
| gate_lo_o | output | NUM_LEVELS-1 | Lower switch command per carrier |
| level_o | output | LW | Signed synthesized level (sum of ±1 comparisons) |

## Verification
The carrier counters are invisible at the ports. A carrier that is out of phase, stuck, or turning at the wrong value therefore first appears as a wrong gate pattern on the first enabled clock, when the start phases are compared, or within one switching period, as a wrong high-time count. A reference register that captures at the wrong moment alters the gates on the clock after the mid-ramp reference change. A wrong peak latch shows up as a high-time count that does not match the captured period. The level sum is compared on every clock against the gate bits, so a miscount shows immediately.

// File: rtl/pscpwm_pkg.sv
package pscpwm_pkg;

  // Position (0 .. 4*peak-1) along the triangle at which carrier idx starts.
  function automatic int start_pos(input int idx, input int ncar, input int peak);
    return (idx * 4 * peak) / ncar;
  endfunction

  // Triangle value at a given position: -peak at 0, +peak at 2*peak.
  function automatic int tri_value(input int pos, input int peak);
    if (pos <= 2 * peak) return pos - peak;
    else                 return 3 * peak - pos;
  endfunction

  // Signed level from comparator bits: each set bit counts +1, each clear -1.
  function automatic int level_of(input logic [31:0] bits, input int ncar);
    int ones;
    ones = 0;
    for (int i = 0; i < ncar; i++) ones += int'(bits[i]);
    return 2 * ones - ncar;
  endfunction

endpackage

// File: rtl/psc_carrier.sv
module psc_carrier #(
  parameter int DW   = 12,
  parameter int NCAR = 2,
  parameter int IDX  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [DW-2:0]        peak,
  output logic signed [DW-1:0] cnt_o,
  output logic                 turn_o
);

  logic signed [DW-1:0] cnt_q;
  logic                 up_q;
  logic signed [DW-1:0] top_v;
  logic signed [DW-1:0] start_v;
  logic                 start_up;
  int                   spos;

  always_comb begin
    spos     = pscpwm_pkg::start_pos(IDX, NCAR, int'(peak));
    start_v  = DW'(pscpwm_pkg::tri_value(spos, int'(peak)));
    start_up = (spos < 2 * int'(peak));
    top_v    = DW'(int'(peak));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (!run) begin
      cnt_q <= start_v;
      up_q  <= start_up;
    end else if (up_q) begin
      if (cnt_q >= top_v) begin
        up_q  <= 1'b0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q <= -top_v) begin
        up_q  <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign turn_o = (cnt_q == top_v) || (cnt_q == -top_v);

  AST_CARRIER_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && top_v != 0) |-> (cnt_q <= top_v && cnt_q >= -top_v)); // R1
  AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && top_v != 0) |->
      (cnt_q == $past(cnt_q) + 1'b1 || cnt_q == $past(cnt_q) - 1'b1)); // R1

endmodule

// File: rtl/psc_compare.sv
module psc_compare #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 turn,
  input  logic signed [DW-1:0] ref_in,
  input  logic signed [DW-1:0] carrier,
  output logic                 hi_o,
  output logic                 lo_o
);

  logic signed [DW-1:0] ref_q;
  logic                 above;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ref_q <= '0;
    else if (!run || turn) ref_q <= ref_in;
  end

  assign above = (ref_q >= carrier);
  assign hi_o  = run & above;
  assign lo_o  = run & ~above;

  AST_GATE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hi_o != lo_o)); // R3
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!hi_o && !lo_o)); // R6
  AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(turn)) |-> $stable(ref_q)); // R4

endmodule

// File: rtl/psc_level.sv
module psc_level #(
  parameter int NCAR = 2,
  parameter int LW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [NCAR-1:0]      hi,
  output logic signed [LW-1:0] level_o
);

  int lvl;

  always_comb begin
    lvl     = pscpwm_pkg::level_of(32'(hi), NCAR);
    level_o = run ? LW'(lvl) : '0;
  end

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (int'(level_o) <= NCAR && int'(level_o) >= -NCAR &&
             ((int'(level_o) + NCAR) % 2) == 0)); // R5
  AST_LEVEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (level_o == '0)); // R6

endmodule

// File: rtl/phase_shift_pwm.sv
module phase_shift_pwm #(
  parameter  int NUM_LEVELS = 3,
  parameter  int DW         = 12,
  localparam int NCAR       = NUM_LEVELS - 1,
  localparam int LW         = $clog2(NCAR + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [DW-2:0]        peak_i,
  input  logic signed [DW-1:0] ref_i,
  output logic [NCAR-1:0]      gate_hi_o,
  output logic [NCAR-1:0]      gate_lo_o,
  output logic signed [LW-1:0] level_o
);

  logic [DW-2:0]        peak_q;
  logic [DW-2:0]        peak_eff;
  logic [NCAR-1:0]      turn;
  logic signed [DW-1:0] carrier [NCAR];

  // The period is frozen while running; it follows peak_i only while parked.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     peak_q <= '0;
    else if (!en_i) peak_q <= peak_i;
  end

  assign peak_eff = en_i ? peak_q : peak_i;

  for (genvar k = 0; k < NCAR; k++) begin : g_leg
    psc_carrier #(.DW(DW), .NCAR(NCAR), .IDX(k)) u_carrier (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (en_i),
      .peak   (peak_eff),
      .cnt_o  (carrier[k]),
      .turn_o (turn[k])
    );
    psc_compare #(.DW(DW)) u_compare (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (en_i),
      .turn    (turn[k]),
      .ref_in  (ref_i),
      .carrier (carrier[k]),
      .hi_o    (gate_hi_o[k]),
      .lo_o    (gate_lo_o[k])
    );
  end

  psc_level #(.NCAR(NCAR), .LW(LW)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en_i),
    .hi      (gate_hi_o),
    .level_o (level_o)
  );

  AST_PEAK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && $past(en_i)) |-> $stable(peak_q)); // R7

endmodule

// File: tb/test_phase_shift_pwm.sv
`timescale 1ns/1ps
module test_phase_shift_pwm;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              en;
  logic [10:0]       pk;
  logic signed [11:0] rf;

  logic [1:0]        hiA, loA;
  logic signed [2:0] lvA;
  logic [3:0]        hiB, loB;
  logic signed [3:0] lvB;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // Bench model state: triangle position and captured reference per carrier
  int mq   [2][4];
  int mref [2][4];
  int mpeak = 1;
  int NC   [2] = '{2, 4};

  always #2.5 clk = ~clk;

  phase_shift_pwm i_phase_shift_pwm (
    .clk(clk), .rst_n(rst_n), .en_i(en), .peak_i(pk), .ref_i(rf),
    .gate_hi_o(hiA), .gate_lo_o(loA), .level_o(lvA));

  phase_shift_pwm #(.NUM_LEVELS(5)) i_phase_shift_pwm_5 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .peak_i(pk), .ref_i(rf),
    .gate_hi_o(hiB), .gate_lo_o(loB), .level_o(lvB));

  function automatic int tv(input int q, input int p);
    return (q <= 2 * p) ? q - p : 3 * p - q;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic model_update();
    if (!en) begin
      mpeak = int'(pk);
      for (int i = 0; i < 2; i++)
        for (int k = 0; k < NC[i]; k++) begin
          mq[i][k]   = k * (4 * mpeak) / NC[i];
          mref[i][k] = int'(rf);
        end
    end else begin
      for (int i = 0; i < 2; i++)
        for (int k = 0; k < NC[i]; k++) begin
          int v;
          v = tv(mq[i][k], mpeak);
          if (v == mpeak || v == -mpeak) mref[i][k] = int'(rf);
          mq[i][k] = (mq[i][k] + 1) % (4 * mpeak);
        end
    end
  endtask

  task automatic compare(input string req);
    for (int i = 0; i < 2; i++) begin
      int eh, el, elv, cnt, ah, al, alv;
      eh = 0; cnt = 0;
      for (int k = 0; k < NC[i]; k++)
        if (en && mref[i][k] >= tv(mq[i][k], mpeak)) begin
          eh |= (1 << k);
          cnt++;
        end
      el  = en ? (~eh & ((1 << NC[i]) - 1)) : 0;
      elv = en ? 2 * cnt - NC[i] : 0;
      ah  = (i == 0) ? int'(hiA) : int'(hiB);
      al  = (i == 0) ? int'(loA) : int'(loB);
      alv = (i == 0) ? int'(lvA) : int'(lvB);
      chk(ah == eh && al == el, req, ah * 16 + al, eh * 16 + el);
      chk(alv == elv, "R5", alv, elv);
    end
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(req);
  endtask

  task automatic park(input int p, input int r);
    en = 1'b0; pk = 11'(p); rf = 12'(r);
    tick("R6"); tick("R6");
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; pk = 11'd8; rf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(hiA == 0 && loA == 0 && lvA == 0, "R6", int'(hiA), 0);
    chk(hiB == 0 && loB == 0 && lvB == 0, "R6", int'(hiB), 0);
    tick("R6"); tick("R6");
  endtask

  task automatic t_start_phase();
    park(8, 0);
    en = 1'b1;
    #1;
    compare("R2");
    chk(hiA == 2'b01, "R2", int'(hiA), 1);
    chk(hiB == 4'b1011, "R2", int'(hiB), 11);
    repeat (64) tick("R1");
  endtask

  task automatic t_duty();
    int hcA [2];
    int hcB [4];
    park(8, 3);
    en = 1'b1;
    hcA = '{0, 0}; hcB = '{0, 0, 0, 0};
    repeat (32) begin
      tick("R9");
      for (int k = 0; k < 2; k++) hcA[k] += int'(hiA[k]);
      for (int k = 0; k < 4; k++) hcB[k] += int'(hiB[k]);
    end
    for (int k = 0; k < 2; k++) chk(hcA[k] == 23, "R9", hcA[k], 23);
    for (int k = 0; k < 4; k++) chk(hcB[k] == 23, "R9", hcB[k], 23);
  endtask

  task automatic t_ref_latch();
    park(8, -100);
    en = 1'b1;
    repeat (3) tick("R4");
    rf = 12'sd100;
    tick("R4");
    chk(hiA == 2'b00, "R4", int'(hiA), 0);
    repeat (12) tick("R4");
    chk(hiA == 2'b00, "R4", int'(hiA), 0);
    tick("R4");
    chk(hiA == 2'b11, "R4", int'(hiA), 3);
  endtask

  task automatic t_bounds(input int r, input int expc);
    int h0, h1;
    park(8, r);
    en = 1'b1;
    h0 = 0; h1 = 0;
    repeat (32) begin
      tick("R8");
      h0 += int'(hiA[0]);
      h1 += int'(hiA[1]);
    end
    chk(h0 == expc, "R8", h0, expc);
    chk(h1 == expc, "R8", h1, expc);
  endtask

  task automatic t_peak_hold();
    int h0;
    park(8, 0);
    en = 1'b1;
    tick("R7");
    pk = 11'd3;
    h0 = 0;
    repeat (32) begin
      tick("R7");
      h0 += int'(hiA[0]);
    end
    chk(h0 == 17, "R7", h0, 17);
    park(10, 0);
    en = 1'b1;
    repeat (80) tick("R1");
  endtask

  task automatic t_sine();
    int amax, amin, bmax, bmin;
    park(10, 0);
    en = 1'b1;
    amax = -99; amin = 99; bmax = -99; bmin = 99;
    for (int i = 0; i < 1600; i++) begin
      rf = 12'(int'(8.0 * $sin(6.283185307 * i / 800.0)));
      tick("R5");
      if (int'(lvA) > amax) amax = int'(lvA);
      if (int'(lvA) < amin) amin = int'(lvA);
      if (int'(lvB) > bmax) bmax = int'(lvB);
      if (int'(lvB) < bmin) bmin = int'(lvB);
    end
    chk(amax == 2, "R5", amax, 2);
    chk(amin == -2, "R5", amin, -2);
    chk(bmax >= 2, "R5", bmax, 2);
    chk(bmin <= -2, "R5", bmin, -2);
  endtask

  task automatic t_disable();
    en = 1'b0;
    #1;
    chk(hiA == 0 && loA == 0 && lvA == 0, "R6", int'(loA), 0);
    chk(hiB == 0 && loB == 0 && lvB == 0, "R6", int'(loB), 0);
    repeat (4) tick("R6");
  endtask

  initial begin
    t_reset();
    t_start_phase();
    t_duty();
    t_ref_latch();
    t_bounds(8, 32);
    t_bounds(-8, 1);
    t_bounds(-9, 0);
    t_peak_hold();
    t_sine();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule